// File: doc/BRIEF.md
# Outbound Address Window Translator

This block maps local bus addresses that land inside a fixed outbound region onto 64-bit link addresses. The region starts at a build-time base address and is cut into a fixed number of equal windows. A single shared size code sets how large every window is. Each window holds its own target base address, split into a low and a high word, together with a per-window enable. A global enable bit in a command register switches translation on or off for the whole region.

Two interfaces share one clock. A simple register port writes and reads back the command register, the size register and the window table. A lookup port takes an address with a valid strobe. One cycle later it returns the translated address and a hit flag. It returns the untouched address with a miss flag if the address cannot be translated.

Top module: `obx_translator`

## Requirements
- R1: After synchronous reset the global enable reads back 0, the size code reads back 0, every window's enable (bit 0 of its low word) reads back 0, and out_valid, out_hit and out_miss are 0.
- R2: Register map. Offset 0x004 is the command register, and only bit 1 (global translation enable) is stored; all other bits read as 0. Offset 0x030 holds the size code in bits [2:0], and higher bits written there are dropped. Window n has its low word at 0x200+8n and its high word at 0x204+8n. A read returns its data on cfg_rdata one cycle after cfg_rd. Unmapped or misaligned offsets read as 0 and ignore writes.
- R3: Each window spans 2^code megabytes (2^(20+code) bytes). The window index is (address − region base) shifted right by 20+code.
- R4: On a hit, out_addr = {high word, low word with bit 0 cleared} + (address − region base) mod window size, out_hit = 1, out_miss = 0.
- R5: A lookup whose selected window has its enable bit clear gives out_miss = 1, out_hit = 0 and out_addr equal to the input address zero-extended.
- R6: A lookup below the region base, or whose window index is NUM_WIN or more, misses with the address passed through zero-extended.
- R7: While the global enable is 0, every lookup misses with the address passed through zero-extended.
- R8: out_valid is high exactly one cycle after lk_valid. With out_valid high, exactly one of out_hit and out_miss is 1. With out_valid low, both are 0.
- R9: A lookup in the same cycle as a register write uses the register contents held before that write. The write affects the next lookup.
- R10: The translation sum is a full 64-bit add, so a carry out of the low word reaches the high word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | REG_AW | Register byte offset |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data, one cycle after cfg_rd |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | LADDR_W | Local address to translate |
| out_valid | output | 1 | Lookup result valid |
| out_hit | output | 1 | Address was translated |
| out_miss | output | 1 | Address passed through untranslated |
| out_addr | output | 2*DATA_W | Translated or passed-through address |

## Verification
A register write and a lookup can land on the same clock edge, and the write may target the very window the lookup selects. The bench provokes this by raising cfg_we with a new low word for window 0 while lk_valid presents an address inside window 0. The write either moves the window's base or clears its enable. The result of that lookup must carry the old base or old hit status, and an identical lookup one cycle later must show the new value.

// File: rtl/obx_pkg.sv
package obx_pkg;

  // Megabyte granule of the window size code
  localparam int unsigned MB_SHIFT = 20;

  // Register byte offsets. The window table pitch of 8 and the
  // low/high split on bit 2 are decoded by the register port.
  localparam int unsigned OFF_CMD      = 32'h004;
  localparam int unsigned OFF_SIZE     = 32'h030;
  localparam int unsigned OFF_WIN_BASE = 32'h200;
  localparam int unsigned WIN_PITCH    = 8;

  // Bit of the command register that gates all translation
  localparam int unsigned CMD_XLATE_BIT = 1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CMD,
    SEL_SIZE,
    SEL_WLO,
    SEL_WHI
  } reg_sel_e;

endpackage

// File: rtl/obx_decode.sv
module obx_decode
  import obx_pkg::*;
#(
  parameter int unsigned REG_AW  = 12,
  parameter int unsigned NUM_WIN = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_WIN)
) (
  input  logic [REG_AW-1:0] addr,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  idx
);

  localparam int unsigned WIN_SPAN = WIN_PITCH * NUM_WIN;

  logic [REG_AW-1:0] rel;
  logic              in_table;

  // Offset from the start of the window table; wraps high below it
  assign rel      = addr - REG_AW'(OFF_WIN_BASE);
  assign in_table = (32'(rel) < WIN_SPAN) && (rel[1:0] == 2'b00);
  assign idx      = IDX_W'(rel >> 3);

  always_comb begin
    sel = SEL_NONE;
    if (addr == REG_AW'(OFF_CMD)) begin
      sel = SEL_CMD;
    end else if (addr == REG_AW'(OFF_SIZE)) begin
      sel = SEL_SIZE;
    end else if (in_table) begin
      sel = rel[2] ? SEL_WHI : SEL_WLO;
    end
  end

endmodule

// File: rtl/obx_regfile.sv
module obx_regfile
  import obx_pkg::*;
#(
  parameter int unsigned REG_AW  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_WIN = 32,
  parameter int unsigned CODE_W  = 3,
  localparam int unsigned IDX_W  = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_rd,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              xlate_en,
  output logic [CODE_W-1:0] size_code,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic              lk_win_en,
  output logic [DATA_W-1:0] lk_lo,
  output logic [DATA_W-1:0] lk_hi
);

  reg_sel_e         sel;
  logic [IDX_W-1:0] widx;

  obx_decode #(
    .REG_AW (REG_AW),
    .NUM_WIN(NUM_WIN)
  ) u_decode (
    .addr(cfg_addr),
    .sel (sel),
    .idx (widx)
  );

  // Per-window enables need a reset value, so they live in flops.
  logic [NUM_WIN-1:0] win_en;
  // Base words carry no reset so they map onto distributed RAM.
  logic [DATA_W-2:0]  lo_mem [NUM_WIN];
  logic [DATA_W-1:0]  hi_mem [NUM_WIN];

  always_ff @(posedge clk) begin
    if (rst) begin
      xlate_en  <= 1'b0;
      size_code <= '0;
      win_en    <= '0;
    end else if (cfg_we) begin
      case (sel)
        SEL_CMD:  xlate_en     <= cfg_wdata[CMD_XLATE_BIT];
        SEL_SIZE: size_code    <= cfg_wdata[CODE_W-1:0];
        SEL_WLO:  win_en[widx] <= cfg_wdata[0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_we && sel == SEL_WLO) begin
      lo_mem[widx] <= cfg_wdata[DATA_W-1:1];
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_we && sel == SEL_WHI) begin
      hi_mem[widx] <= cfg_wdata;
    end
  end

  // Register readback
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (cfg_rd) begin
      case (sel)
        SEL_CMD: begin
          cfg_rdata                <= '0;
          cfg_rdata[CMD_XLATE_BIT] <= xlate_en;
        end
        SEL_SIZE: cfg_rdata <= DATA_W'(size_code);
        SEL_WLO:  cfg_rdata <= {lo_mem[widx], win_en[widx]};
        SEL_WHI:  cfg_rdata <= hi_mem[widx];
        default:  cfg_rdata <= '0;
      endcase
    end
  end

  // Lookup read port, asynchronous: returns pre-write contents
  assign lk_win_en = win_en[lk_idx];
  assign lk_lo     = {lo_mem[lk_idx], 1'b0};
  assign lk_hi     = hi_mem[lk_idx];

endmodule

// File: rtl/obx_locate.sv
module obx_locate
  import obx_pkg::*;
#(
  parameter int unsigned LADDR_W     = 32,
  parameter int unsigned NUM_WIN     = 32,
  parameter int unsigned CODE_W      = 3,
  parameter logic [LADDR_W-1:0] REGION_BASE = 32'h6000_0000,
  localparam int unsigned IDX_W      = $clog2(NUM_WIN),
  localparam int unsigned SH_W       = $clog2(LADDR_W + 1) + 1
) (
  input  logic [LADDR_W-1:0] addr,
  input  logic [CODE_W-1:0]  size_code,
  output logic [IDX_W-1:0]   idx,
  output logic [LADDR_W-1:0] offset,
  output logic               in_region
);

  logic [LADDR_W:0]   rel_full;
  logic [LADDR_W-1:0] rel;
  logic [LADDR_W-1:0] win_num;
  logic [LADDR_W-1:0] win_mask;
  logic [SH_W-1:0]    shamt;
  logic               below;

  assign rel_full = {1'b0, addr} - {1'b0, REGION_BASE};
  assign below    = rel_full[LADDR_W];
  assign rel      = rel_full[LADDR_W-1:0];

  assign shamt    = SH_W'(MB_SHIFT) + SH_W'(size_code);
  assign win_num  = rel >> shamt;
  assign win_mask = (LADDR_W'(1) << shamt) - LADDR_W'(1);

  assign idx       = win_num[IDX_W-1:0];
  assign offset    = rel & win_mask;
  assign in_region = !below && (win_num < LADDR_W'(NUM_WIN));

endmodule

// File: rtl/obx_result.sv
module obx_result #(
  parameter int unsigned LADDR_W = 32,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned OADDR_W = 2 * DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_valid,
  input  logic [LADDR_W-1:0] lk_addr,
  input  logic               xlate_en,
  input  logic               in_region,
  input  logic               win_en,
  input  logic [DATA_W-1:0]  win_lo,
  input  logic [DATA_W-1:0]  win_hi,
  input  logic [LADDR_W-1:0] offset,
  output logic               out_valid,
  output logic               out_hit,
  output logic               out_miss,
  output logic [OADDR_W-1:0] out_addr
);

  logic               take;
  logic [OADDR_W-1:0] xlated;

  assign take   = xlate_en && in_region && win_en;
  assign xlated = {win_hi, win_lo} + OADDR_W'(offset);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_miss  <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= lk_valid;
      out_hit   <= lk_valid && take;
      out_miss  <= lk_valid && !take;
      if (lk_valid) begin
        out_addr <= take ? xlated : OADDR_W'(lk_addr);
      end
    end
  end

endmodule

// File: rtl/obx_translator.sv
module obx_translator #(
  parameter int unsigned REG_AW  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned LADDR_W = 32,
  parameter int unsigned NUM_WIN = 32,
  parameter int unsigned CODE_W  = 3,
  parameter logic [LADDR_W-1:0] REGION_BASE = 32'h6000_0000,
  localparam int unsigned OADDR_W = 2 * DATA_W,
  localparam int unsigned IDX_W   = $clog2(NUM_WIN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic               cfg_rd,
  input  logic [REG_AW-1:0]  cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  input  logic               lk_valid,
  input  logic [LADDR_W-1:0] lk_addr,
  output logic               out_valid,
  output logic               out_hit,
  output logic               out_miss,
  output logic [OADDR_W-1:0] out_addr
);

  logic               xlate_en;
  logic [CODE_W-1:0]  size_code;
  logic [IDX_W-1:0]   lk_idx;
  logic [LADDR_W-1:0] lk_offset;
  logic               lk_in_region;
  logic               lk_win_en;
  logic [DATA_W-1:0]  lk_lo;
  logic [DATA_W-1:0]  lk_hi;

  obx_regfile #(
    .REG_AW (REG_AW),
    .DATA_W (DATA_W),
    .NUM_WIN(NUM_WIN),
    .CODE_W (CODE_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_rd   (cfg_rd),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .xlate_en (xlate_en),
    .size_code(size_code),
    .lk_idx   (lk_idx),
    .lk_win_en(lk_win_en),
    .lk_lo    (lk_lo),
    .lk_hi    (lk_hi)
  );

  obx_locate #(
    .LADDR_W    (LADDR_W),
    .NUM_WIN    (NUM_WIN),
    .CODE_W     (CODE_W),
    .REGION_BASE(REGION_BASE)
  ) u_locate (
    .addr     (lk_addr),
    .size_code(size_code),
    .idx      (lk_idx),
    .offset   (lk_offset),
    .in_region(lk_in_region)
  );

  obx_result #(
    .LADDR_W(LADDR_W),
    .DATA_W (DATA_W)
  ) u_result (
    .clk      (clk),
    .rst      (rst),
    .lk_valid (lk_valid),
    .lk_addr  (lk_addr),
    .xlate_en (xlate_en),
    .in_region(lk_in_region),
    .win_en   (lk_win_en),
    .win_lo   (lk_lo),
    .win_hi   (lk_hi),
    .offset   (lk_offset),
    .out_valid(out_valid),
    .out_hit  (out_hit),
    .out_miss (out_miss),
    .out_addr (out_addr)
  );

endmodule

// File: rtl/obx_translator_chk.sv
module obx_translator_chk #(
  parameter int unsigned REG_AW  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned LADDR_W = 32,
  localparam int unsigned OADDR_W = 2 * DATA_W
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_we,
  input logic [REG_AW-1:0]  cfg_addr,
  input logic [DATA_W-1:0]  cfg_wdata,
  input logic               lk_valid,
  input logic [LADDR_W-1:0] lk_addr,
  input logic               out_valid,
  input logic               out_hit,
  input logic               out_miss,
  input logic [OADDR_W-1:0] out_addr
);

  logic rst_q;
  logic en_shadow;

  always_ff @(posedge clk) rst_q <= rst;

  // Independent copy of the global enable, tracked from port writes
  always_ff @(posedge clk) begin
    if (rst) begin
      en_shadow <= 1'b0;
    end else if (cfg_we && cfg_addr == REG_AW'(obx_pkg::OFF_CMD)) begin
      en_shadow <= cfg_wdata[obx_pkg::CMD_XLATE_BIT];
    end
  end

  // R1: outputs idle right after a reset edge
  always @(posedge clk) begin
    if (rst_q === 1'b1) begin
      p_reset_idle_r1: assert (!out_valid && !out_hit && !out_miss)
        else $error("outputs not idle after reset");
    end
  end

  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> out_valid);

  p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !out_valid);

  p_one_flag_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_hit != out_miss));

  p_idle_flags_r8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_hit && !out_miss));

  p_miss_passthru_r5: assert property (@(posedge clk) disable iff (rst)
    out_miss |-> (out_addr == OADDR_W'($past(lk_addr))));

  p_global_off_r7: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !en_shadow) |=> (out_miss && !out_hit));

endmodule

bind obx_translator obx_translator_chk #(
  .REG_AW (REG_AW),
  .DATA_W (DATA_W),
  .LADDR_W(LADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .cfg_wdata(cfg_wdata),
  .lk_valid (lk_valid),
  .lk_addr  (lk_addr),
  .out_valid(out_valid),
  .out_hit  (out_hit),
  .out_miss (out_miss),
  .out_addr (out_addr)
);

// File: tb/obx_translator_bench.sv
`timescale 1ns/1ps
module obx_translator_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        out_valid, out_hit, out_miss;
  logic [63:0] out_addr;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  obx_translator u_obx_translator (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .out_valid(out_valid), .out_hit(out_hit), .out_miss(out_miss),
    .out_addr(out_addr)
  );

  // {address, expected hit, expected out_addr}; 8 MB windows, base 0x6000_0000
  localparam logic [96:0] VEC [8] = '{
    {32'h6000_0000, 1'b1, 64'h0000_0000_1000_0000},
    {32'h6012_3456, 1'b1, 64'h0000_0000_1012_3456},
    {32'h6080_0010, 1'b1, 64'h0000_0001_1080_0010},
    {32'h6280_0004, 1'b0, 64'h0000_0000_6280_0004},
    {32'h6FFF_FFFF, 1'b1, 64'h0000_001F_1FFF_FFFF},
    {32'h7000_0000, 1'b0, 64'h0000_0000_7000_0000},
    {32'h5FFF_FFFF, 1'b0, 64'h0000_0000_5FFF_FFFF},
    {32'h6300_0008, 1'b1, 64'h0000_0006_1300_0008}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  // Result packed as {valid, hit, miss, addr}
  task automatic look(input string req, input logic [31:0] a,
                      input logic hit_e, input logic [63:0] exp);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(req, {61'(0), out_valid, out_hit, out_miss}, {61'(0), 1'b1, hit_e, !hit_e});
    chk(req, out_addr, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 out flags", {61'(0), out_valid, out_hit, out_miss}, 64'd0);
    rd(12'h004, d); chk("R1 cmd", 64'(d), 64'd0);
    rd(12'h030, d); chk("R1 size", 64'(d), 64'd0);
    rd(12'h200, d); chk("R1 win0 enable", 64'(d[0]), 64'd0);
    // R7: global enable clear after reset
    look("R7 disabled after reset", 32'h6000_0000, 1'b0, 64'h6000_0000);

    // Program 1:1-style table: window n -> 0x1000_0000 + n*8MB, high word n
    wr(12'h030, 32'h0000_0003);
    for (int n = 0; n < 32; n++) begin
      wr(12'(12'h200 + 8 * n), 32'h1000_0000 + (n << 23) + ((n != 5) ? 1 : 0));
      wr(12'(12'h204 + 8 * n), n);
    end
    wr(12'h004, 32'h0000_0002);

    // R2: readback
    rd(12'h004, d); chk("R2 cmd readback", 64'(d), 64'h2);
    rd(12'h2FC, d); chk("R2 win31 high", 64'(d), 64'h1F);
    rd(12'h2F8, d); chk("R2 win31 low", 64'(d), 64'h1F80_0001);
    rd(12'h228, d); chk("R2 win5 low", 64'(d), 64'h1280_0000);
    rd(12'h100, d); chk("R2 unmapped", 64'(d), 64'd0);
    rd(12'h203, d); chk("R2 misaligned", 64'(d), 64'd0);

    // R3 R4 R5 R6: vector table
    for (int i = 0; i < 8; i++) begin
      look("R4/R5/R6 vector", VEC[i][96:65], VEC[i][64], VEC[i][63:0]);
    end

    // R8: idle cycle gives no result
    @(negedge clk);
    chk("R8 idle", {61'(0), out_valid, out_hit, out_miss}, 64'd0);

    // R10: carry into high word
    wr(12'h210, 32'hFFF0_0001);
    wr(12'h214, 32'h0000_0007);
    look("R10 carry", 32'h6120_0000, 1'b1, 64'h0000_0008_0010_0000);

    // R3: size code 0 (1 MB windows), upper bits dropped per R2
    wr(12'h030, 32'hFFFF_FFF8);
    rd(12'h030, d); chk("R2 size upper bits dropped", 64'(d), 64'd0);
    look("R3 code0 window3", 32'h6030_0005, 1'b1, 64'h0000_0003_1180_0005);
    look("R6 code0 past end", 32'h6200_0000, 1'b0, 64'h6200_0000);
    // R3: size code 7 (128 MB windows)
    wr(12'h030, 32'h7);
    look("R3 code7 window1", 32'h6FFF_FFFF, 1'b1, 64'h0000_0001_187F_FFFF);
    wr(12'h030, 32'h3);

    // R7: global disable
    wr(12'h004, 32'h0);
    look("R7 global off", 32'h6000_0000, 1'b0, 64'h6000_0000);
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, d); chk("R2 cmd other bits", 64'(d), 64'h2);

    // R9: write and lookup in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 12'h200; cfg_wdata = 32'h2000_0001;
    lk_valid = 1'b1; lk_addr = 32'h6000_0040;
    @(negedge clk);
    cfg_we = 1'b0; lk_valid = 1'b0;
    chk("R9 old base used", out_addr, 64'h1000_0040);
    look("R9 new base next", 32'h6000_0040, 1'b1, 64'h2000_0040);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 12'h200; cfg_wdata = 32'h2000_0000;
    lk_valid = 1'b1; lk_addr = 32'h6000_0040;
    @(negedge clk);
    cfg_we = 1'b0; lk_valid = 1'b0;
    chk("R9 old enable used", {62'(0), out_hit, out_miss}, 64'b10);
    look("R9 disabled next", 32'h6000_0040, 1'b0, 64'h6000_0040);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule